// File: doc/BRIEF.md
# Flash Status Register and Write-Protect Guard

This block holds the status byte of a serial NOR flash and judges every decoded command against it. Each command arrives as an opcode with a 24-bit target address and, for a status write, a data byte. The guard compares the command against the write-enable latch, the status-lock bit, the level of the write-protect pin, a top/bottom select bit, the block-protection field and the busy flag. It then returns one accept or reject verdict. An accepted program or erase raises the busy flag and sends a one-cycle start pulse to the program/erase engine. The engine's done pulse later clears both the busy flag and the write-enable latch.

The command side is a valid/ready stream, and `cmd_ready` is held high. A command is consumed on every rising edge where `cmd_valid` is high, so the sender never sees back-pressure. The verdict for that command appears on `verdict_valid`/`verdict_accept` in the next cycle, and the status byte is updated at the same time. The protected region is worked out for an array of 2^BLK_W 64 KB blocks, which is 256 blocks by default.

Top module: `flash_sr_guard`

## Requirements
- R1: After reset the status byte is 0x00 and `verdict_valid`, `verdict_accept` and `eng_start` are low.
- R2: When not busy, opcode 06h sets the write-enable latch (status bit 1) and opcode 04h clears it. Both are accepted.
- R3: A status write (01h), a program (02h, 32h), a sector erase (20h), a block erase (52h, D8h) or a chip erase (C7h, 60h) is rejected when status bit 1 is 0, and the status byte is left unchanged.
- R4: A status write is rejected, with the status byte unchanged, when status bit 7 is 1 and `wp_n` is low. Otherwise, if it is not locked out by R3 or R8, it copies data bits 7..2 into status bits 7..2 and clears bit 1.
- R5: Let the protection field be status bits 5..2, call it n, and let the block index be address bits 23..16. A value n of 1 to 8 protects 2^(n-1) blocks. These are the highest-numbered blocks when `tb_sel` is 0 and the lowest-numbered when it is 1. A value of 9 or more protects every block, and 0 protects none. A program or sector/block erase aimed at a protected block is rejected, and status bit 1 stays as it was.
- R6: A chip erase is accepted only when status bits 5..2 are all 0.
- R7: An accepted program or erase sets status bit 0 and pulses `eng_start` high for one cycle, together with the verdict. Status bit 1 holds until `eng_done`, and that pulse clears both bit 0 and bit 1.
- R8: While status bit 0 is 1, only the status read (05h) is accepted. Array reads (03h, 0Bh) and every other command are rejected with no effect on the status byte.
- R9: `cmd_ready` is always high. Each cycle with `cmd_valid` high produces exactly one verdict in the following cycle. `verdict_valid` is low in every other cycle, and `verdict_accept` is never high without it.
- R10: Any opcode not listed in R2 to R8 is rejected and leaves the status byte unchanged. An `eng_done` pulse while bit 0 is 0 has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low asynchronous reset |
| cmd_valid | input | 1 | Command present this cycle |
| cmd_ready | output | 1 | Command taken (always 1) |
| cmd_op | input | 8 | Decoded instruction opcode |
| cmd_addr | input | 24 | Target byte address |
| cmd_wdata | input | 8 | New status value for a status write |
| wp_n | input | 1 | Level of the write-protect pin, low = protect |
| tb_sel | input | 1 | 0 = protect from top, 1 = from bottom |
| eng_done | input | 1 | Program/erase engine finished pulse |
| eng_start | output | 1 | Start pulse for an accepted program/erase |
| verdict_valid | output | 1 | Verdict for the previous cycle's command |
| verdict_accept | output | 1 | 1 = command executed, 0 = ignored |
| status_o | output | 8 | Current status byte |

## Verification
A seeded random stream mixes all opcode classes, including unknown ones. It uses random addresses, random status-write data, and random `wp_n` and `tb_sel` levels, and it inserts engine done pulses. This exercises many combinations of latch, lock, busy and protection state, and a bench model predicts each verdict. Directed cases pin down the protection edges: block 127 against block 128 at field value 8 from the top, block 0 against block 1 at value 1 from the bottom, and values 0 and 9. These separate an off-by-one in the range from a top/bottom swap. Further directed cases cover the status lock with the pin low against the pin high, a chip erase with a non-zero field, and a read against a status read while busy. Together they show whether the lockout, lock and chip-erase rules are each applied on their own.

// File: rtl/fsg_pkg.sv
package fsg_pkg;

  localparam logic [7:0] OP_WREN  = 8'h06;
  localparam logic [7:0] OP_WRDI  = 8'h04;
  localparam logic [7:0] OP_WRSR  = 8'h01;
  localparam logic [7:0] OP_RDSR  = 8'h05;
  localparam logic [7:0] OP_RD    = 8'h03;
  localparam logic [7:0] OP_FRD   = 8'h0B;
  localparam logic [7:0] OP_PP    = 8'h02;
  localparam logic [7:0] OP_PPQ   = 8'h32;
  localparam logic [7:0] OP_SE    = 8'h20;
  localparam logic [7:0] OP_BE32  = 8'h52;
  localparam logic [7:0] OP_BE64  = 8'hD8;
  localparam logic [7:0] OP_CE_A  = 8'hC7;
  localparam logic [7:0] OP_CE_B  = 8'h60;

  // status byte bit positions
  localparam int SR_BUSY = 0;
  localparam int SR_WEN  = 1;
  localparam int SR_PROT_LO = 2;
  localparam int SR_PROT_HI = 5;
  localparam int SR_QUAD = 6;
  localparam int SR_LOCK = 7;

  typedef enum logic [3:0] {
    CL_NONE,
    CL_WREN,
    CL_WRDI,
    CL_WRSR,
    CL_RDSR,
    CL_READ,
    CL_PROG,
    CL_ERASE,
    CL_CHIP
  } cmd_class_e;

endpackage

// File: rtl/fsg_decode.sv
module fsg_decode
  import fsg_pkg::*;
(
  input  logic [7:0]  op_i,
  output cmd_class_e  cls_o
);

  always_comb begin
    unique case (op_i)
      OP_WREN:          cls_o = CL_WREN;
      OP_WRDI:          cls_o = CL_WRDI;
      OP_WRSR:          cls_o = CL_WRSR;
      OP_RDSR:          cls_o = CL_RDSR;
      OP_RD, OP_FRD:    cls_o = CL_READ;
      OP_PP, OP_PPQ:    cls_o = CL_PROG;
      OP_SE, OP_BE32,
      OP_BE64:          cls_o = CL_ERASE;
      OP_CE_A, OP_CE_B: cls_o = CL_CHIP;
      default:          cls_o = CL_NONE;
    endcase
  end

endmodule

// File: rtl/fsg_protect.sv
module fsg_protect #(
  parameter int ADDR_W = 24,
  parameter int BLK_W  = 8,
  parameter int BP_W   = 4
) (
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [BP_W-1:0]   bp_i,
  input  logic              tb_sel_i,
  output logic              hit_o
);

  localparam int CNT_W = BLK_W + 1;

  logic [BLK_W-1:0] blk;
  logic [BLK_W-1:0] blk_from_top;
  logic [CNT_W-1:0] span;

  assign blk          = addr_i[ADDR_W-1 -: BLK_W];
  assign blk_from_top = ~blk;

  // number of protected blocks: 0, a power of two, or the whole array
  always_comb begin
    if (bp_i == '0)
      span = '0;
    else if (int'(bp_i) > BLK_W)
      span = CNT_W'(1) << BLK_W;
    else
      span = CNT_W'(1) << (int'(bp_i) - 1);
  end

  assign hit_o = tb_sel_i ? ({1'b0, blk} < span)
                          : ({1'b0, blk_from_top} < span);

endmodule

// File: rtl/fsg_status_reg.sv
module fsg_status_reg
  import fsg_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        fire_i,
  input  cmd_class_e  cls_i,
  input  logic [7:0]  wdata_i,
  input  logic        done_i,
  output logic [7:0]  sr_o
);

  logic [7:0] sr_q, sr_d;

  always_comb begin
    sr_d = sr_q;
    if (fire_i) begin
      unique case (cls_i)
        CL_WREN: sr_d[SR_WEN] = 1'b1;
        CL_WRDI: sr_d[SR_WEN] = 1'b0;
        CL_WRSR: begin
          sr_d[SR_LOCK:SR_PROT_LO] = wdata_i[SR_LOCK:SR_PROT_LO];
          sr_d[SR_WEN]             = 1'b0;
        end
        CL_PROG, CL_ERASE, CL_CHIP: sr_d[SR_BUSY] = 1'b1;
        default: ;
      endcase
    end
    if (done_i && sr_q[SR_BUSY]) begin
      sr_d[SR_BUSY] = 1'b0;
      sr_d[SR_WEN]  = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sr_q <= '0;
    else        sr_q <= sr_d;
  end

  assign sr_o = sr_q;

endmodule

// File: rtl/flash_sr_guard.sv
module flash_sr_guard
  import fsg_pkg::*;
#(
  parameter int ADDR_W = 24,
  parameter int BLK_W  = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_valid,
  output logic              cmd_ready,
  input  logic [7:0]        cmd_op,
  input  logic [ADDR_W-1:0] cmd_addr,
  input  logic [7:0]        cmd_wdata,
  input  logic              wp_n,
  input  logic              tb_sel,
  input  logic              eng_done,
  output logic              eng_start,
  output logic              verdict_valid,
  output logic              verdict_accept,
  output logic [7:0]        status_o
);

  localparam int BP_W = SR_PROT_HI - SR_PROT_LO + 1;

  cmd_class_e      cls;
  logic            in_prot;
  logic            ok;
  logic            fire;
  logic            busy, wen, locked;
  logic [BP_W-1:0] bp;
  logic [7:0]      sr;

  fsg_decode u_dec (
    .op_i (cmd_op),
    .cls_o(cls)
  );

  assign bp = sr[SR_PROT_HI:SR_PROT_LO];

  fsg_protect #(.ADDR_W(ADDR_W), .BLK_W(BLK_W), .BP_W(BP_W)) u_prot (
    .addr_i  (cmd_addr),
    .bp_i    (bp),
    .tb_sel_i(tb_sel),
    .hit_o   (in_prot)
  );

  assign busy   = sr[SR_BUSY];
  assign wen    = sr[SR_WEN];
  assign locked = sr[SR_LOCK] && !wp_n;

  always_comb begin
    unique case (cls)
      CL_RDSR:                   ok = 1'b1;
      CL_WREN, CL_WRDI, CL_READ: ok = !busy;
      CL_WRSR:                   ok = !busy && wen && !locked;
      CL_PROG, CL_ERASE:         ok = !busy && wen && !in_prot;
      CL_CHIP:                   ok = !busy && wen && (bp == '0);
      default:                   ok = 1'b0;
    endcase
  end

  assign fire      = cmd_valid && ok;
  assign cmd_ready = 1'b1;

  fsg_status_reg u_sr (
    .clk    (clk),
    .rst_n  (rst_n),
    .fire_i (fire),
    .cls_i  (cls),
    .wdata_i(cmd_wdata),
    .done_i (eng_done),
    .sr_o   (sr)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      verdict_valid  <= 1'b0;
      verdict_accept <= 1'b0;
      eng_start      <= 1'b0;
    end else begin
      verdict_valid  <= cmd_valid;
      verdict_accept <= fire;
      eng_start      <= fire && (cls == CL_PROG || cls == CL_ERASE || cls == CL_CHIP);
    end
  end

  assign status_o = sr;

  AST_START_SETS_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    eng_start |-> status_o[SR_BUSY]); // R7
  AST_BUSY_DROP_ON_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(status_o[SR_BUSY]) |-> $past(eng_done)); // R7
  AST_BUSY_LOCKOUT: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && status_o[SR_BUSY] && cmd_op != OP_RDSR) |=> !verdict_accept); // R8
  AST_SR_LOCKED: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd_op == OP_WRSR && status_o[SR_LOCK] && !wp_n && !eng_done)
      |=> $stable(status_o)); // R4
  AST_CHIP_GUARD: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cls == CL_CHIP && status_o[SR_PROT_HI:SR_PROT_LO] != '0) |=> !eng_start); // R6
  AST_NEED_WEN: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && !status_o[SR_WEN] &&
     (cls == CL_WRSR || cls == CL_PROG || cls == CL_ERASE || cls == CL_CHIP))
      |=> !verdict_accept); // R3
  AST_VERDICT_PAIRED: assert property (@(posedge clk) disable iff (!rst_n)
    verdict_accept |-> verdict_valid); // R9

endmodule

// File: tb/flash_sr_guard_bench.sv
`timescale 1ns/1ps
module flash_sr_guard_bench;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cmd_valid = 1'b0;
  logic        cmd_ready;
  logic [7:0]  cmd_op = '0;
  logic [23:0] cmd_addr = '0;
  logic [7:0]  cmd_wdata = '0;
  logic        wp_n = 1'b1;
  logic        tb_sel = 1'b0;
  logic        eng_done = 1'b0;
  logic        eng_start, verdict_valid, verdict_accept;
  logic [7:0]  status_o;

  int n_chk = 0;
  int n_bad = 0;
  logic [7:0] m_sr = '0;

  always #2.5 clk = ~clk;

  flash_sr_guard u_flash_sr_guard (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
    .cmd_op(cmd_op), .cmd_addr(cmd_addr), .cmd_wdata(cmd_wdata), .wp_n(wp_n),
    .tb_sel(tb_sel), .eng_done(eng_done), .eng_start(eng_start),
    .verdict_valid(verdict_valid), .verdict_accept(verdict_accept), .status_o(status_o)
  );

  task automatic chk(input string req, input string what, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  function automatic bit is_protected(input [23:0] a, input [3:0] n, input bit tb);
    int cnt, b;
    b = int'(a[23:16]);
    if (n == 0) cnt = 0;
    else if (n >= 9) cnt = 256;
    else cnt = 1 << (n - 1);
    return tb ? (b < cnt) : (b >= 256 - cnt);
  endfunction

  // 0 none,1 wren,2 wrdi,3 wrsr,4 rdsr,5 read,6 prog/erase,7 chip
  function automatic int kind(input [7:0] op);
    case (op)
      8'h06: return 1;
      8'h04: return 2;
      8'h01: return 3;
      8'h05: return 4;
      8'h03, 8'h0B: return 5;
      8'h02, 8'h32, 8'h20, 8'h52, 8'hD8: return 6;
      8'hC7, 8'h60: return 7;
      default: return 0;
    endcase
  endfunction

  function automatic bit exp_ok(input [7:0] op, input [23:0] a, input bit wp, input bit tb,
                                input [7:0] sr);
    bit bsy, we;
    bsy = sr[0];
    we  = sr[1];
    case (kind(op))
      4: return 1'b1;
      1, 2, 5: return !bsy;
      3: return !bsy && we && !(sr[7] && !wp);
      6: return !bsy && we && !is_protected(a, sr[5:2], tb);
      7: return !bsy && we && (sr[5:2] == 4'd0);
      default: return 1'b0;
    endcase
  endfunction

  function automatic string req_of(input [7:0] op, input [7:0] sr);
    if (sr[0] && kind(op) != 0) return "R8";
    case (kind(op))
      1, 2: return "R2";
      3: return sr[1] ? "R4" : "R3";
      6: return sr[1] ? "R5" : "R3";
      7: return sr[1] ? "R6" : "R3";
      4, 5: return "R8";
      default: return "R10";
    endcase
  endfunction

  task automatic do_cmd(input [7:0] op, input [23:0] a, input [7:0] wd);
    bit ok;
    string r;
    int k;
    ok = exp_ok(op, a, wp_n, tb_sel, m_sr);
    r  = req_of(op, m_sr);
    k  = kind(op);
    cmd_op = op; cmd_addr = a; cmd_wdata = wd; cmd_valid = 1'b1;
    if (ok) begin
      case (k)
        1: m_sr[1] = 1'b1;
        2: m_sr[1] = 1'b0;
        3: begin m_sr[7:2] = wd[7:2]; m_sr[1] = 1'b0; end
        6, 7: m_sr[0] = 1'b1;
        default: ;
      endcase
    end
    @(negedge clk);
    cmd_valid = 1'b0;
    chk("R9", "verdict_valid", int'(verdict_valid), 1);
    chk(r, "accept", int'(verdict_accept), int'(ok));
    chk("R7", "eng_start", int'(eng_start), int'(ok && (k == 6 || k == 7)));
    chk(r, "status", int'(status_o), int'(m_sr));
  endtask

  task automatic idle_chk;
    @(negedge clk);
    chk("R9", "idle verdict_valid", int'(verdict_valid), 0);
    chk("R9", "idle verdict_accept", int'(verdict_accept), 0);
  endtask

  task automatic pulse_done;
    string r;
    r = m_sr[0] ? "R7" : "R10";
    eng_done = 1'b1;
    if (m_sr[0]) begin m_sr[0] = 1'b0; m_sr[1] = 1'b0; end
    @(negedge clk);
    eng_done = 1'b0;
    chk(r, "status after done", int'(status_o), int'(m_sr));
  endtask

  task automatic set_sr(input [7:0] v);
    wp_n = 1'b1;
    do_cmd(8'h06, 24'h0, 8'h0);
    do_cmd(8'h01, 24'h0, v);
  endtask

  task automatic finish_run;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    logic [7:0] ops [16];
    void'($urandom(32'd4242));
    ops = '{8'h06, 8'h04, 8'h01, 8'h05, 8'h03, 8'h0B, 8'h02, 8'h32,
            8'h20, 8'h52, 8'hD8, 8'hC7, 8'h60, 8'hAB, 8'h00, 8'h06};
    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1", "status reset", int'(status_o), 0);
    chk("R1", "verdict_valid reset", int'(verdict_valid), 0);
    chk("R1", "eng_start reset", int'(eng_start), 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R9", "ready", int'(cmd_ready), 1);

    // R3 no write enable
    do_cmd(8'h02, 24'h000100, 8'h0);
    do_cmd(8'h01, 24'h0, 8'hFC);
    // R2
    do_cmd(8'h06, 24'h0, 8'h0);
    do_cmd(8'h04, 24'h0, 8'h0);
    idle_chk();
    // R10 unknown opcode and stray done
    do_cmd(8'hAB, 24'h0, 8'h0);
    pulse_done();

    // R5 top, n=8: block 127 free, block 128 protected
    tb_sel = 1'b0;
    set_sr(8'h20);
    do_cmd(8'h06, 24'h0, 8'h0);
    do_cmd(8'h20, 24'h800000, 8'h0);
    do_cmd(8'hD8, 24'h7F0000, 8'h0);
    pulse_done();
    // R6 chip erase with non-zero field
    do_cmd(8'h06, 24'h0, 8'h0);
    do_cmd(8'hC7, 24'h0, 8'h0);
    // R5 bottom, n=1: block 0 protected, block 1 free
    tb_sel = 1'b1;
    set_sr(8'h04);
    do_cmd(8'h06, 24'h0, 8'h0);
    do_cmd(8'h02, 24'h00FFFF, 8'h0);
    do_cmd(8'h02, 24'h010000, 8'h0);
    // R8 busy: read rejected, status read accepted
    do_cmd(8'h03, 24'h0, 8'h0);
    do_cmd(8'h05, 24'h0, 8'h0);
    do_cmd(8'h06, 24'h0, 8'h0);
    pulse_done();
    // R5 n=9 all protected
    set_sr(8'h24);
    do_cmd(8'h06, 24'h0, 8'h0);
    do_cmd(8'h52, 24'h400000, 8'h0);
    // R4 lock with pin low, then pin high
    set_sr(8'h80);
    wp_n = 1'b0;
    do_cmd(8'h06, 24'h0, 8'h0);
    do_cmd(8'h01, 24'h0, 8'h00);
    wp_n = 1'b1;
    do_cmd(8'h01, 24'h0, 8'h00);
    // R6 chip erase with zero field
    do_cmd(8'h06, 24'h0, 8'h0);
    do_cmd(8'h60, 24'h0, 8'h0);
    pulse_done();

    // random mix
    for (int i = 0; i < 600; i++) begin
      logic [7:0] op;
      op = ops[$urandom_range(0, 15)];
      wp_n = ($urandom_range(0, 3) != 0);
      tb_sel = $urandom_range(0, 1);
      if (m_sr[0] && $urandom_range(0, 2) == 0) pulse_done();
      if ($urandom_range(0, 9) == 0) idle_chk();
      if (op == 8'h01 && $urandom_range(0, 1) == 1)
        do_cmd(8'h06, 24'h0, 8'h0);
      do_cmd(op, {$urandom_range(0, 255), 16'($urandom)}[23:0],
             8'($urandom_range(0, 255)) & 8'hBF | (8'($urandom_range(0, 1)) << 6));
      if ($urandom_range(0, 4) == 0) begin
        do_cmd(8'h06, 24'h0, 8'h0);
      end
    end
    finish_run();
  end

endmodule